// File: doc/BRIEF.md
# Serial Register Access Port

This block sits behind a single-wire serial link, presented here as a clocked bit stream with a one-cycle bit-valid strobe. It puts the first eight strobed bits together into a command byte. The top bit of that byte is the direction bit, and the low seven bits are a register address. Other logic on the chip holds the registers. This port reaches them through a plain register-file interface: it drives an address, a write enable and write data, and it reads back read data.

After a read command, the port drives the addressed register's byte back onto the link, one bit per strobe. After a write command, it gathers the next eight strobed bits and sends them to the register file as a single write pulse. The write goes out only if the address is marked valid and writable in the per-address map, and the status register at address 01h never accepts a write. A write that is dropped still uses up its data byte, so the link stays aligned on byte boundaries.

Top module: `serial_reg_port`

## Requirements
- R1: A synchronous active-high `rst` puts the port back to collecting a new command and throws away any partial byte. While it is held, and in the cycle after it, `drive_en`, `bit_out` and `reg_we` are 0.
- R2: A bit is taken only in a cycle where `bit_vld` is 1. The value of `bit_in` in any other cycle has no effect.
- R3: Bits travel least significant bit first. A command is complete on its eighth accepted bit. That eighth bit (bit 7) sets the direction: 0 means read and 1 means write.
- R4: Command bits 0 to 6 form the address, with bit 0 as the least significant bit. The address appears on `reg_addr` in the cycle after the eighth command bit and stays there until the next command completes.
- R5: After a read command, `drive_en` is 1 until the eighth read strobe has been taken. In the cycle of the k-th read strobe (k counting from 0), `bit_out` equals bit k of `reg_rdata`. When `drive_en` is 0, `bit_out` is 0.
- R6: A read of an address whose `addr_valid` bit is 0 returns all zeros on `bit_out`.
- R7: After a write command, the next eight accepted bits form the data byte, least significant bit first. If the address is valid and writable, `reg_we` is 1 for exactly one cycle, the cycle after the eighth data bit, and in that cycle `reg_wdata` holds the byte and `reg_addr` holds the address.
- R8: A write to an address whose `addr_valid` or `addr_writable` bit is 0 produces no `reg_we` pulse. Its eight data bits are still taken in.
- R9: Address 01h is read-only. Writes to it are dropped even if the map marks it writable.
- R10: When a read or write transaction finishes, the port goes back to collecting a command. A reset in the middle of a data byte cancels that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Strobe that marks a bit slot |
| bit_in | input | 1 | Serial bit from the host |
| bit_out | output | 1 | Serial read bit toward the host |
| drive_en | output | 1 | High while the port owns the line for a read |
| reg_addr | output | ADDR_W | Register address decoded from the command |
| reg_rdata | input | DATA_W | Read data for `reg_addr` |
| reg_we | output | 1 | One-cycle register write pulse |
| reg_wdata | output | DATA_W | Data to write |
| addr_valid | input | 2**ADDR_W | Per-address implemented flag |
| addr_writable | input | 2**ADDR_W | Per-address writable flag |

## Verification
Some properties are checked in every cycle. A write pulse never reaches an address that is unmapped, not writable or the status address. The pulse lasts one cycle and never overlaps a read. The line stays quiet outside a read and while an unmapped address is being read. The address does not change under a write pulse. Only the bench scenarios can show the rest. These are the bit order and byte framing, ignoring of non-strobed bits, the exact contents that land at each of the 128 addresses after a full write-then-read sweep with varied strobe spacing, and the cancelling of partial bytes by reset.

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int STATUS_ADDR = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bit_vld,
  input  logic                     bit_in,
  output logic                     bit_out,
  output logic                     drive_en,
  output logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_rdata,
  output logic                     reg_we,
  output logic [DATA_W-1:0]        reg_wdata,
  input  logic [(1<<ADDR_W)-1:0]   addr_valid,
  input  logic [(1<<ADDR_W)-1:0]   addr_writable
);
  localparam int CMD_W   = ADDR_W + 1;
  localparam int LEN_MAX = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CNT_W   = $clog2(LEN_MAX);

  typedef enum logic [1:0] {S_CMD, S_RD, S_WR} state_t;

  state_t              state;
  logic [CNT_W-1:0]    cnt;
  logic [ADDR_W-1:0]   cmd_sr;
  logic [DATA_W-2:0]   dat_sr;

  wire cmd_last  = cnt == CNT_W'(CMD_W - 1);
  wire dat_last  = cnt == CNT_W'(DATA_W - 1);
  wire can_write = addr_valid[reg_addr] & addr_writable[reg_addr]
                 & (reg_addr != ADDR_W'(STATUS_ADDR));

  assign drive_en = state == S_RD;
  assign bit_out  = drive_en & addr_valid[reg_addr] & reg_rdata[cnt];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_CMD;
      cnt       <= '0;
      cmd_sr    <= '0;
      dat_sr    <= '0;
      reg_addr  <= '0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (bit_vld) begin
        case (state)
          S_CMD: begin
            if (cmd_last) begin
              cnt      <= '0;
              reg_addr <= cmd_sr;
              state    <= bit_in ? S_WR : S_RD;
            end else begin
              cmd_sr <= {bit_in, cmd_sr[ADDR_W-1:1]};
              cnt    <= cnt + 1'b1;
            end
          end
          S_RD: begin
            if (dat_last) begin
              cnt   <= '0;
              state <= S_CMD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_WR: begin
            if (dat_last) begin
              cnt       <= '0;
              state     <= S_CMD;
              reg_we    <= can_write;
              reg_wdata <= {bit_in, dat_sr};
            end else begin
              dat_sr <= {bit_in, dat_sr[DATA_W-2:1]};
              cnt    <= cnt + 1'b1;
            end
          end
          default: state <= S_CMD;
        endcase
      end
    end
  end
endmodule

module serial_reg_port_chk #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int STATUS_ADDR = 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bit_out,
  input logic                    drive_en,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic                    reg_we,
  input logic [DATA_W-1:0]       reg_wdata,
  input logic [(1<<ADDR_W)-1:0]  addr_valid,
  input logic [(1<<ADDR_W)-1:0]  addr_writable
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d && !rst)
      p_after_reset_quiet_r1: assert (!drive_en && !reg_we && !bit_out);
  end

  p_we_mapped_r8: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (addr_valid[reg_addr] && addr_writable[reg_addr]));
  p_status_ro_r9: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> reg_addr != ADDR_W'(STATUS_ADDR));
  p_we_single_r7: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
  p_we_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> $stable(reg_addr));
  p_we_not_reading_r10: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !drive_en);
  p_line_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !drive_en |-> !bit_out);
  p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (drive_en && !addr_valid[reg_addr]) |-> !bit_out);
endmodule

bind serial_reg_port serial_reg_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bit_out(bit_out), .drive_en(drive_en),
  .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .addr_valid(addr_valid), .addr_writable(addr_writable)
);

// File: tb/serial_reg_port_test.sv
module serial_reg_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0, bit_in = 1'b0;
  logic bit_out, drive_en, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_rdata, reg_wdata;
  logic [NA-1:0] addr_valid, addr_writable;
  logic [7:0] mem [NA];
  logic [7:0] exp_mem [NA];
  int checks = 0, fails = 0, exp_we_total = 0, we_total = 0;
  bit done = 0;
  logic s_out, s_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_reg_port uut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .bit_out(bit_out), .drive_en(drive_en), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .addr_valid(addr_valid), .addr_writable(addr_writable)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) if (reg_we) begin
    mem[reg_addr] <= reg_wdata;
    we_total <= we_total + 1;
  end

  function automatic bit can_wr(int a);
    return addr_valid[a] && addr_writable[a] && a != 1;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic strobe(input logic b, input int gap);
    @(negedge clk);
    bit_vld = 1'b1; bit_in = b;
    s_out = bit_out; s_en = drive_en;
    if (gap > 0) begin
      @(negedge clk);
      bit_vld = 1'b0; bit_in = ~b;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic send_cmd(input logic dir, input int a, input int gap);
    for (int i = 0; i < 8; i++)
      strobe(i < 7 ? a[i] : dir, i == 7 ? 0 : gap);
  endtask

  task automatic do_write(input int a, input logic [7:0] d, input int gap);
    bit ew;
    send_cmd(1'b1, a, gap);
    for (int i = 0; i < 8; i++) strobe(d[i], i == 7 ? 0 : gap);
    @(negedge clk);
    bit_vld = 1'b0;
    ew = can_wr(a);
    // R7 R8 R9: pulse only for valid, writable, non-status addresses
    check(reg_we === ew, "R7/R8/R9 reg_we", reg_we, ew);
    if (ew) begin
      check(reg_wdata === d && reg_addr === a[6:0], "R7 R4 data/addr",
            {reg_addr, reg_wdata}, {a[6:0], d});
      exp_mem[a] = d;
      exp_we_total++;
    end
  endtask

  task automatic do_read(input int a, input int gap);
    logic [7:0] got, expv;
    bit en_ok = 1;
    send_cmd(1'b0, a, gap);
    for (int i = 0; i < 8; i++) begin
      strobe(1'b0, i == 7 ? 0 : gap);
      got[i] = s_out;
      if (s_en !== 1'b1) en_ok = 0;
    end
    @(negedge clk);
    bit_vld = 1'b0;
    expv = addr_valid[a] ? exp_mem[a] : 8'h00;
    // R5 R6: LSB-first readback, zeros for unmapped
    check(got === expv && en_ok, "R5/R6 read data", got, expv);
    // R10: back to command collection, line released
    check(drive_en === 1'b0, "R10 drive_en released", drive_en, 0);
  endtask

  initial begin
    for (int a = 0; a < NA; a++) begin
      addr_valid[a]    = (a % 3) != 2;
      addr_writable[a] = (a % 2) == 0 || a == 1;
      mem[a]     = 8'(a * 7 + 3);
      exp_mem[a] = 8'(a * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R1: outputs quiet while in reset
    check(drive_en === 0 && reg_we === 0 && bit_out === 0, "R1 reset state",
          {drive_en, reg_we, bit_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(drive_en === 0 && reg_we === 0, "R1 after reset", {drive_en, reg_we}, 0);

    // R2 R3 R4 R7 R8 R9: write sweep with varied strobe spacing
    for (int a = 0; a < NA; a++) do_write(a, 8'(a ^ 8'hA5), a % 3);
    for (int a = 0; a < NA; a++) do_read(a, (a + 1) % 3);
    check(we_total == exp_we_total, "R7 total write pulses", we_total, exp_we_total);

    // R10 R1: reset mid-command, then an aligned read must still work
    for (int i = 0; i < 4; i++) strobe(1'b1, 1);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    do_read(4, 0);

    // R10: reset mid-data cancels the write
    send_cmd(1'b1, 6, 1);
    for (int i = 0; i < 5; i++) strobe(1'b1, 1);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    check(reg_we === 1'b0, "R10 no pulse after reset", reg_we, 0);
    do_read(6, 2);
    check(we_total == exp_we_total, "R10 cancelled write", we_total, exp_we_total);

    // R9: explicit status address write dropped, read shows old value
    do_write(1, 8'h3C, 0);
    do_read(1, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule